// File: doc/BRIEF.md
# Block Access Password Guard

This unit keeps the access rules for each block of a memory that is split into equal blocks. Every block has a protection mode, a flag that limits it to privileged requesters, an optional password of one to three 32-bit words, a lock bit and a hide bit. Software sets these through a small register window. The unit then answers, with no added cycle, whether a given requester may read or write a given block. A single requester asks at a time and gives a block number, a privileged/unprivileged flag and the access kind.

Block 0 also acts as the gate for the whole memory. Its protection is merged into the rights of every other block, and while block 0 is locked behind its password no other block can be reached. To unlock a block, software streams that block's password words into one register, last word first. A separate hide mask closes blocks until the next reset. A mass-erase input returns every block to its open, password-free state in one cycle. All state lives in flops and is lost at reset.

Top module: `blk_guard`

## Requirements
- R1: After reset, and in the cycle after `massErase` is high at a clock edge, every block has mode 0, no password, no privileged-only flag and no hide bit. Every block therefore grants both read and write to any requester, and it accepts a new first password word.
- R2: Register addresses: 0 = block select (low bits), 1 = protection, 2/3/4 = password words 0/1/2, 5 = unlock, 6 = hide. A write to password word k of the selected block is taken only when exactly k words are already stored and the value is not 0xFFFFFFFF. Any other password write changes nothing and drives `cfgErr` high for the cycle after that write edge. Because of this rule a password can be built only once.
- R3: Reading address 5 returns 1 in bit 0 when the selected block has no password or is unlocked, and 0 when it is locked. A block whose password has just been set is unlocked.
- R4: Writing 0xFFFFFFFF to address 5 locks the selected block if it has a password, and it restarts any partial unlock sequence.
- R5: Other writes to address 5 are compared with the stored words in reverse order, last word first. The block unlocks on the write that completes a fully matching sequence of the stored length. Any mismatch leaves it locked.
- R6: Once address 5 has taken as many words as the stored length without unlocking, every further word is ignored until a 0xFFFFFFFF restart. A restart also happens on a select write or a password write.
- R7: The protection register holds the mode in bits [1:0]. Mode 0 gives read and write when the block is unlocked or has no password, and read only when it is locked. Mode 1, and the reserved mode 3, give read and write only when a password is set and the block is unlocked, and nothing otherwise. Mode 2 gives read only when the block is unlocked or has no password, and nothing when it is locked. Write is never granted without read.
- R8: Protection bit 2 marks a block as privileged-only. An unprivileged request (`qSuper`=0) to such a block is then denied both read and write.
- R9: For any block N ≥ 1, the privileged-only flag is the OR of its own flag and block 0's flag. Each of its rights is the AND of its own mode result and block 0's mode result. While block 0 is locked, block N gets nothing.
- R10: Writing a mask to address 6 sets the hide bit of every block whose bit is 1. Bit 0 is ignored, and writing 0 clears nothing. A hidden block grants nothing until reset or mass erase.
- R11: `grant` equals `wrOk` when `qWrite` is 1 and `rdOk` when it is 0.
- R12: Register writes act at the clock edge where `regWrEn` is high. `rdOk`, `wrOk`, `grant` and `regRdData` follow the query inputs and the stored state with no register, so a write shows up in them just after its edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address (read and write) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for regAddr on the selected block |
| cfgErr | output | 1 | Rejected password write, one cycle after it |
| massErase | input | 1 | Clear all protection state |
| qBlk | input | 2 | Block number of the access being judged |
| qSuper | input | 1 | Requester is privileged |
| qWrite | input | 1 | Access kind: 1 write, 0 read |
| rdOk | output | 1 | Read permitted |
| wrOk | output | 1 | Write permitted |
| grant | output | 1 | Permission for the access kind given |

## Verification
The permission outputs and the register read data carry no register. They are due just after the edge that takes a write, and the R12 check confirms that they hold their old value before that edge. `cfgErr` is the only registered result: it is high for exactly the one cycle that follows a rejected write edge. The bench drives every input on the falling edge, lets one rising edge pass, and samples all results at the next falling edge. That point sits inside the one-cycle `cfgErr` window and after the state update. Only then does the bench flip `qWrite`, to read both halves of `grant` combinationally.

// File: rtl/blkg_pkg.sv
package blkg_pkg;

  localparam int PW_MAX   = 3;
  localparam int PW_IDX_W = 2;

  typedef enum logic [2:0] {
    ADDR_SEL  = 3'd0,
    ADDR_PROT = 3'd1,
    ADDR_PW0  = 3'd2,
    ADDR_PW1  = 3'd3,
    ADDR_PW2  = 3'd4,
    ADDR_UNLK = 3'd5,
    ADDR_HIDE = 3'd6
  } reg_addr_e;

  typedef enum logic [1:0] {
    MODE_OPEN   = 2'd0,
    MODE_PWONLY = 2'd1,
    MODE_RDONLY = 2'd2,
    MODE_RSVD   = 2'd3
  } prot_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                protWe;
    logic                pwWe;
    logic [PW_IDX_W-1:0] pwIdx;
    logic                lockSel;
    logic                unlockSel;
    logic                hideWe;
    logic                erase;
  } strobe_t;

  // returns {read, write} rights of one block from its own settings
  function automatic logic [1:0] modePerm(prot_mode_e mode, logic hasPw, logic locked);
    logic [1:0] perm;
    case (mode)
      MODE_OPEN:   perm = {1'b1, !locked};
      MODE_RDONLY: perm = {!locked, 1'b0};
      default:     perm = {2{hasPw && !locked}};
    endcase
    return perm;
  endfunction

endpackage

// File: rtl/blkg_ctrl.sv
module blkg_ctrl
  import blkg_pkg::*;
#(
  parameter int NUM_BLK = 4,
  parameter int DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [2:0]          regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic                massErase,
  input  logic [PW_IDX_W-1:0] selLen,
  input  logic                selWordHit,
  output logic [$clog2(NUM_BLK)-1:0] selBlk,
  output logic [PW_IDX_W-1:0] seqIdx,
  output strobe_t             strb,
  output logic                cfgErr
);

  localparam int BLK_W = $clog2(NUM_BLK);

  logic                wrAllOnes;
  logic                isPwWr;
  logic                isSelWr;
  logic                unlkWr;
  logic [PW_IDX_W-1:0] pwIdxW;
  logic                pwOk;
  logic                hasPw;
  logic [PW_IDX_W-1:0] seqCnt;
  logic                seqBad;
  logic                seqOpen;

  assign wrAllOnes = &regWrData;
  assign isPwWr    = regWrEn && !massErase &&
                     (regAddr == ADDR_PW0 || regAddr == ADDR_PW1 || regAddr == ADDR_PW2);
  assign isSelWr   = regWrEn && !massErase && (regAddr == ADDR_SEL);
  assign unlkWr    = regWrEn && !massErase && (regAddr == ADDR_UNLK);
  assign pwIdxW    = PW_IDX_W'(regAddr - 3'(ADDR_PW0));
  assign pwOk      = isPwWr && !wrAllOnes && (selLen == pwIdxW);
  assign hasPw     = (selLen != '0);
  assign seqOpen   = !seqBad && (seqCnt < selLen);
  assign seqIdx    = seqCnt;

  always_comb begin
    strb           = '0;
    strb.erase     = massErase;
    strb.protWe    = regWrEn && !massErase && (regAddr == ADDR_PROT);
    strb.hideWe    = regWrEn && !massErase && (regAddr == ADDR_HIDE);
    strb.pwWe      = pwOk;
    strb.pwIdx     = pwIdxW;
    strb.lockSel   = unlkWr && wrAllOnes;
    strb.unlockSel = unlkWr && !wrAllOnes && hasPw && seqOpen && selWordHit &&
                     ((seqCnt + 2'd1) == selLen);
  end

  // unlock sequencer, block select and error flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selBlk <= '0;
      seqCnt <= '0;
      seqBad <= 1'b0;
      cfgErr <= 1'b0;
    end else begin
      cfgErr <= isPwWr && !pwOk;
      if (isSelWr) selBlk <= regWrData[BLK_W-1:0];
      if (massErase || isSelWr || strb.lockSel || pwOk) begin
        seqCnt <= '0;
        seqBad <= 1'b0;
      end else if (unlkWr && hasPw) begin
        if (seqCnt < selLen) begin
          seqCnt <= seqCnt + 2'd1;
          if (!selWordHit) seqBad <= 1'b1;
        end else begin
          seqBad <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/blkg_store.sv
module blkg_store
  import blkg_pkg::*;
#(
  parameter int NUM_BLK = 4,
  parameter int DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strb,
  input  logic [$clog2(NUM_BLK)-1:0] selBlk,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [PW_IDX_W-1:0]        seqIdx,
  input  logic [$clog2(NUM_BLK)-1:0] qBlk,
  input  logic                       qSuper,
  output logic [PW_IDX_W-1:0]        selLen,
  output logic                       selWordHit,
  output logic                       selOpen,
  output prot_mode_e                 selMode,
  output logic                       selSup,
  output logic [NUM_BLK-1:0]         hideVec,
  output logic                       blk0Locked,
  output logic                       rdOk,
  output logic                       wrOk
);

  localparam int BLK_W = $clog2(NUM_BLK);

  prot_mode_e          modeV [NUM_BLK];
  logic [PW_IDX_W-1:0] lenV  [NUM_BLK];
  logic [DATA_W-1:0]   pwV   [NUM_BLK][PW_MAX];
  logic [1:0]          permV [NUM_BLK];
  logic [NUM_BLK-1:0]  supV;
  logic [NUM_BLK-1:0]  lockedV;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    prot_mode_e          mode;
    logic [PW_IDX_W-1:0] len;
    logic                sup;
    logic                lock;
    logic                hide;
    logic [DATA_W-1:0]   pw [PW_MAX];
    logic                selHit;

    assign selHit = (selBlk == BLK_W'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mode <= MODE_OPEN;
        len  <= '0;
        sup  <= 1'b0;
        lock <= 1'b0;
        hide <= 1'b0;
      end else if (strb.erase) begin
        mode <= MODE_OPEN;
        len  <= '0;
        sup  <= 1'b0;
        lock <= 1'b0;
        hide <= 1'b0;
      end else begin
        if (selHit && strb.protWe) begin
          mode <= prot_mode_e'(wrData[1:0]);
          sup  <= wrData[2];
        end
        if (selHit && strb.pwWe) begin
          len  <= len + 2'd1;
          lock <= 1'b0;
        end else if (selHit && strb.lockSel && (len != '0)) begin
          lock <= 1'b1;
        end else if (selHit && strb.unlockSel) begin
          lock <= 1'b0;
        end
        if (strb.hideWe && wrData[b] && (b != 0)) hide <= 1'b1;
      end
    end

    // password words need no reset: a zero length hides them
    always_ff @(posedge clk) begin
      if (selHit && strb.pwWe && !strb.erase) pw[strb.pwIdx] <= wrData;
    end

    assign modeV[b]   = mode;
    assign lenV[b]    = len;
    assign pwV[b]     = pw;
    assign supV[b]    = sup;
    assign lockedV[b] = lock && (len != '0);
    assign hideVec[b] = hide;
    assign permV[b]   = modePerm(mode, len != '0, lock && (len != '0));
  end

  // selected-block view for the control and register read
  logic [PW_IDX_W-1:0] expIdx;

  assign selLen  = lenV[selBlk];
  assign selOpen = !lockedV[selBlk];
  assign selMode = modeV[selBlk];
  assign selSup  = supV[selBlk];
  assign expIdx  = selLen - 2'd1 - seqIdx;

  always_comb begin
    selWordHit = 1'b0;
    for (int w = 0; w < PW_MAX; w++) begin
      if (expIdx == PW_IDX_W'(w)) selWordHit = (pwV[selBlk][w] == wrData);
    end
  end

  // access decision for the queried block
  logic [1:0] ownPerm;
  logic [1:0] mergedPerm;
  logic       needSup;
  logic       deny;

  assign blk0Locked = lockedV[0];
  assign ownPerm    = permV[qBlk];
  assign mergedPerm = (qBlk == '0) ? ownPerm : (ownPerm & permV[0] & {2{!lockedV[0]}});
  assign needSup    = supV[qBlk] | supV[0];
  assign deny       = hideVec[qBlk] | (needSup & !qSuper);
  assign rdOk       = mergedPerm[1] & !deny;
  assign wrOk       = mergedPerm[0] & !deny;

endmodule

// File: rtl/blk_guard.sv
module blk_guard
  import blkg_pkg::*;
#(
  parameter int NUM_BLK = 4,
  parameter int DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWrEn,
  input  logic [2:0]                 regAddr,
  input  logic [DATA_W-1:0]          regWrData,
  output logic [DATA_W-1:0]          regRdData,
  output logic                       cfgErr,
  input  logic                       massErase,
  input  logic [$clog2(NUM_BLK)-1:0] qBlk,
  input  logic                       qSuper,
  input  logic                       qWrite,
  output logic                       rdOk,
  output logic                       wrOk,
  output logic                       grant
);

  localparam int BLK_W = $clog2(NUM_BLK);

  strobe_t             strb;
  logic [BLK_W-1:0]    selBlk;
  logic [PW_IDX_W-1:0] seqIdx;
  logic [PW_IDX_W-1:0] selLen;
  logic                selWordHit;
  logic                selOpen;
  prot_mode_e          selMode;
  logic                selSup;
  logic [NUM_BLK-1:0]  hideVec;
  logic                blk0Locked;

  blkg_ctrl #(.NUM_BLK(NUM_BLK), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .massErase(massErase), .selLen(selLen),
    .selWordHit(selWordHit), .selBlk(selBlk), .seqIdx(seqIdx),
    .strb(strb), .cfgErr(cfgErr)
  );

  blkg_store #(.NUM_BLK(NUM_BLK), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .selBlk(selBlk), .wrData(regWrData),
    .seqIdx(seqIdx), .qBlk(qBlk), .qSuper(qSuper), .selLen(selLen),
    .selWordHit(selWordHit), .selOpen(selOpen), .selMode(selMode),
    .selSup(selSup), .hideVec(hideVec), .blk0Locked(blk0Locked),
    .rdOk(rdOk), .wrOk(wrOk)
  );

  assign grant = qWrite ? wrOk : rdOk;

  always_comb begin
    case (regAddr)
      ADDR_SEL:  regRdData = DATA_W'(selBlk);
      ADDR_PROT: regRdData = DATA_W'({selSup, selMode});
      ADDR_UNLK: regRdData = DATA_W'(selOpen);
      default:   regRdData = '0;
    endcase
  end

endmodule

// File: rtl/blk_guard_chk.sv
module blk_guard_chk #(
  parameter int NUM_BLK = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       massErase,
  input logic                       regWrEn,
  input logic                       cfgErr,
  input logic [$clog2(NUM_BLK)-1:0] qBlk,
  input logic                       rdOk,
  input logic                       wrOk,
  input logic [NUM_BLK-1:0]         hideVec,
  input logic                       blk0Locked
);

  p_erase_opens_r1: assert property (@(posedge clk) disable iff (!rstN)
    massErase |=> (rdOk && wrOk));

  p_err_needs_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> $past(regWrEn));

  p_write_implies_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrOk |-> rdOk);

  p_gate_closed_r9: assert property (@(posedge clk) disable iff (!rstN)
    (blk0Locked && (qBlk != '0)) |-> (!rdOk && !wrOk));

  p_hidden_closed_r10: assert property (@(posedge clk) disable iff (!rstN)
    hideVec[qBlk] |-> (!rdOk && !wrOk));

  p_hide_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(massErase) |-> ((hideVec & $past(hideVec)) == $past(hideVec)));

endmodule

bind blk_guard blk_guard_chk #(.NUM_BLK(NUM_BLK)) u_chk (
  .clk(clk), .rstN(rstN), .massErase(massErase), .regWrEn(regWrEn),
  .cfgErr(cfgErr), .qBlk(qBlk), .rdOk(rdOk), .wrOk(wrOk),
  .hideVec(hideVec), .blk0Locked(blk0Locked)
);

// File: tb/blk_guard_test.sv
`timescale 1ns/100ps
module blk_guard_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic        cfgErr;
  logic        massErase = 1'b0;
  logic [1:0]  qBlk = 2'd0;
  logic        qSuper = 1'b0;
  logic        qWrite = 1'b0;
  logic        rdOk, wrOk, grant;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  blk_guard uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cfgErr(cfgErr),
    .massErase(massErase), .qBlk(qBlk), .qSuper(qSuper), .qWrite(qWrite),
    .rdOk(rdOk), .wrOk(wrOk), .grant(grant)
  );

  typedef struct packed {
    logic        doWr;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [1:0]  qb;
    logic        qs;
    logic        eRd;
    logic        eWr;
    logic        eErr;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 44;
  // addr: 0 sel, 1 prot, 2..4 pw words, 5 unlock, 6 hide
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 32'h0,        2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd1},  // R1 open after reset
    '{1'b1, 3'd0, 32'h1,        2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd2},  // R2 select block 1
    '{1'b1, 3'd1, 32'h2,        2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 mode 2 no pw
    '{1'b1, 3'd1, 32'h1,        2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 mode 1 no pw
    '{1'b1, 3'd1, 32'h4,        2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 user denied
    '{1'b0, 3'd0, 32'h0,        2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 privileged ok
    '{1'b1, 3'd1, 32'h0,        2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd7},  // R7 back to mode 0
    '{1'b1, 3'd2, 32'h11110000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd2},  // R2 first word taken
    '{1'b1, 3'd3, 32'hFFFFFFFF, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd2},  // R2 all-ones rejected
    '{1'b1, 3'd4, 32'h00002222, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd2},  // R2 out of order
    '{1'b1, 3'd3, 32'h00002222, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd2},  // R2 second word taken
    '{1'b1, 3'd2, 32'h00000005, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd2},  // R2 set only once
    '{1'b1, 3'd5, 32'hFFFFFFFF, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 lock, mode 0
    '{1'b1, 3'd5, 32'h11110000, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 wrong order
    '{1'b1, 3'd5, 32'h00002222, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 still locked
    '{1'b1, 3'd5, 32'hFFFFFFFF, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 restart
    '{1'b1, 3'd5, 32'h00002222, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 last word first
    '{1'b1, 3'd5, 32'h11110000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd5},  // R5 unlocked
    '{1'b1, 3'd5, 32'hFFFFFFFF, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 lock again
    '{1'b1, 3'd1, 32'h2,        2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 mode 2 locked
    '{1'b1, 3'd1, 32'h1,        2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 mode 1 locked
    '{1'b1, 3'd5, 32'h00002222, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 partial
    '{1'b1, 3'd5, 32'h11110000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd7},  // R7 mode 1 unlocked
    '{1'b1, 3'd5, 32'hFFFFFFFF, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 lock
    '{1'b1, 3'd5, 32'h00000009, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 bad word
    '{1'b1, 3'd5, 32'h00000009, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 length used
    '{1'b1, 3'd5, 32'h00002222, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 stuck
    '{1'b1, 3'd5, 32'h11110000, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 still stuck
    '{1'b1, 3'd5, 32'hFFFFFFFF, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 restart
    '{1'b1, 3'd5, 32'h00002222, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},
    '{1'b1, 3'd5, 32'h11110000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd5},  // R5 unlocked
    '{1'b1, 3'd0, 32'h0,        2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd9},  // R9 select block 0
    '{1'b1, 3'd1, 32'h2,        2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd9},  // R9 blk0 read-only
    '{1'b1, 3'd1, 32'h4,        2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 blk0 privileged
    '{1'b0, 3'd0, 32'h0,        2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd9},  // R9 privileged ok
    '{1'b1, 3'd1, 32'h0,        2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd9},
    '{1'b1, 3'd2, 32'h0000ABCD, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd2},  // R2 blk0 password
    '{1'b1, 3'd5, 32'hFFFFFFFF, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 blk0 locked
    '{1'b0, 3'd0, 32'h0,        2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 blk0 mode 0 locked
    '{1'b1, 3'd5, 32'h0000ABCD, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd9},  // R9 gate reopened
    '{1'b1, 3'd6, 32'h00000005, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 hide 2
    '{1'b0, 3'd0, 32'h0,        2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd10}, // R10 bit 0 ignored
    '{1'b0, 3'd0, 32'h0,        2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 4'd10}, // R10 others open
    '{1'b1, 3'd6, 32'h00000000, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd10}  // R10 no clear
  };

  task automatic checkVal(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drive at falling edge, one rising edge, back at the next falling edge
  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
    #0.2;
  endtask

  initial begin
    #(5.0 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #0.2;
    // R1 reset state
    qBlk = 2'd0; regAddr = 3'd5;
    #0.2;
    checkVal("R1 reset rdOk", 32'(rdOk), 32'd1);
    checkVal("R1 reset wrOk", 32'(wrOk), 32'd1);
    checkVal("R1 reset cfgErr", 32'(cfgErr), 32'd0);
    checkVal("R3 reset unlock readback", regRdData, 32'd1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      regWrEn = v.doWr; regAddr = v.addr; regWrData = v.data;
      qBlk = v.qb; qSuper = v.qs; qWrite = 1'b0;
      @(posedge clk);
      @(negedge clk);
      regWrEn = 1'b0;
      #0.2;
      checkVal($sformatf("R%0d step %0d rdOk", v.rq, i), 32'(rdOk), 32'(v.eRd));
      checkVal($sformatf("R%0d step %0d wrOk", v.rq, i), 32'(wrOk), 32'(v.eWr));
      checkVal($sformatf("R%0d step %0d cfgErr", v.rq, i), 32'(cfgErr), 32'(v.eErr));
      checkVal($sformatf("R11 step %0d read grant", i), 32'(grant), 32'(v.eRd));
      qWrite = 1'b1;
      #0.2;
      checkVal($sformatf("R11 step %0d write grant", i), 32'(grant), 32'(v.eWr));
      qWrite = 1'b0;
    end

    // R3 unlock readback on block 0 (selected, password 0xABCD, unlocked)
    qSuper = 1'b0; regAddr = 3'd5;
    #0.2;
    checkVal("R3 readback unlocked", regRdData, 32'd1);
    wrReg(3'd5, 32'hFFFFFFFF);
    regAddr = 3'd5;
    #0.2;
    checkVal("R3 readback locked", regRdData, 32'd0);
    wrReg(3'd5, 32'h0000ABCD);
    regAddr = 3'd5;
    #0.2;
    checkVal("R3 readback reopened", regRdData, 32'd1);

    // R12 write visible only after its edge; R7 reserved mode 3
    wrReg(3'd0, 32'd3);
    qBlk = 2'd3;
    regWrEn = 1'b1; regAddr = 3'd1; regWrData = 32'd3;
    #0.5;
    checkVal("R12 before edge wrOk", 32'(wrOk), 32'd1);
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
    #0.2;
    checkVal("R12 after edge wrOk", 32'(wrOk), 32'd0);
    checkVal("R7 mode 3 no pw rdOk", 32'(rdOk), 32'd0);
    regAddr = 3'd1;
    #0.2;
    checkVal("R7 protection readback", regRdData, 32'd3);

    // R1 mass erase
    massErase = 1'b1;
    @(posedge clk);
    @(negedge clk);
    massErase = 1'b0;
    #0.2;
    for (int b = 0; b < 4; b++) begin
      qBlk = 2'(b);
      #0.2;
      checkVal($sformatf("R1 erase blk %0d rdOk", b), 32'(rdOk), 32'd1);
      checkVal($sformatf("R1 erase blk %0d wrOk", b), 32'(wrOk), 32'd1);
    end
    regAddr = 3'd1;
    #0.2;
    checkVal("R1 erase protection cleared", regRdData, 32'd0);
    wrReg(3'd0, 32'd1);
    wrReg(3'd2, 32'h00000077);
    checkVal("R1 erase password cleared", 32'(cfgErr), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule